// File: doc/BRIEF.md
# Charge-Transfer Touch Acquisition Sequencer

This block runs the digital side of a capacitive touch measurement. Up to seven sensing groups are driven with a train of charge-transfer pulses. Each pulse has a programmable high phase and low phase, timed by a prescaled copy of the system clock. The high phase can be stretched by a bounded pseudo-random amount so that the emission spreads over a band of frequencies. Every enabled group counts completed pulse pairs until its sampling comparator, modelled here as a digital input, reports that the sampling capacitor has tripped. The count then serves as the touch measurement.

Software sets up the block through a small write-only register port: a control word, a group-enable word, an interrupt-enable word and a write-one-to-clear word. An acquisition starts either at once or after a condition on a sync input. It ends when every enabled group has tripped, or when any group reaches the selected maximum count. When it ends, the start request drops by itself and the counters keep their values. While no acquisition is running, the group pads are either driven low or released, as the configuration selects.

Top module: `ctouch_acq`

## Requirements
- R1: After a synchronous reset the block is idle. `busy`, `acq_active`, both flags, `irq`, `grp_stat`, every counter and `pad_out` are 0, and `pad_oe` is all ones.
- R2: When no pulses are running (idle, or waiting for sync), each pad has `pad_out`=0. `pad_oe` is 1 when control bit 3 is 0 (drive low) and 0 when that bit is 1 (released input). During pulsing, enabled groups have `pad_oe`=1.
- R3: The control word is written at address 0. Field [8:6] selects the pulse-generator division 2^code. Field [15:12] is the high length minus one and field [19:16] is the low length minus one. With spread spectrum off, the high phase on `pad_out` lasts (hi+1)·2^code system cycles and the low phase lasts (lo+1)·2^code.
- R4: The group enable word is bits [6:0] at address 1. At each pulse-pair end, every enabled, unfinished group counts the pair. If its sampling input is high at that edge, the group finishes. `grp_stat` reports the enables in bits [6:0] and the completion of group g in bit 16+g. Counters of disabled groups stay 0.
- R5: Setting control bit 0 starts an acquisition and clears all counters and completion bits. When all enabled groups have finished, the end flag sets and `busy` falls. The counters then hold until the next start.
- R6: Field [11:9] selects the maximum count 2^(code+8)−1 (code 0 to 6). When a group that has not tripped reaches it, the acquisition ends with both the end flag and the error flag set, and that group's completion bit stays 0.
- R7: With control bit 1 set and bit 2 clear, pulsing waits after start until a falling edge on `sync_in`. A steady high level does not start it.
- R8: With control bits 1 and 2 set, pulsing waits until `sync_in` is high and starts at the first cycle it is seen high.
- R9: With control bit 4 set, each high phase is stretched by j steps, where j lies between 0 and the deviation field [26:20]. A step is one system cycle, or two when bit 5 is set. A deviation of 0 leaves the widths exact.
- R10: The interrupt-enable word at address 2 enables the end flag (bit 0) and the error flag (bit 1). `irq` is the OR of the enabled flags. Writing 1 to bit 0 or bit 1 at address 3 clears the matching flag.
- R11: A start request that combines low code 1 with division code 0, or low code 0 with division code 1, is refused: no acquisition begins.
- R12: While `busy` is high, writes to the control word and to the group enable word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 groups, 2 interrupt enables, 3 flag clear |
| wr_data | input | 32 | Write data |
| sync_in | input | 1 | External start condition input |
| samp_in | input | 7 | Per-group sampling comparator result |
| pad_oe | output | 7 | Per-group pad drive enable |
| pad_out | output | 7 | Per-group pad drive value (charge-transfer pulse) |
| grp_cnt | output | 98 | Per-group pulse counters, 14 bits each, group g at [14g+13:14g] |
| grp_stat | output | 23 | Enables in [6:0], completion bits in [22:16] |
| eoa_flag | output | 1 | End-of-acquisition flag |
| mce_flag | output | 1 | Maximum-count error flag |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Start request pending or acquisition running |
| acq_active | output | 1 | Pulse train running |

## Verification
The bench goes after the pair-end edge. There, a group whose input trips must still count that pair, and a disabled group must not count at all. A design that is off by one reports N−1 pulses or never ends. The maximum-count limits 255 and 511 are run out in full: a wrong compare ends one pulse early or late, or marks the errored group complete. The two refused prescaler/low-length combinations, sync waiting on a high level under falling-edge polarity, configuration writes while busy, and spread-spectrum widths outside 0 to deviation steps are probed as well. Each of these would show up as a started run, an early start, a changed pulse width or a width out of bounds.

// File: rtl/ctouch_pkg.sv
package ctouch_pkg;

    localparam int NGRP  = 7;            // sensing groups
    localparam int CW    = 14;           // counter width (max 16383)
    localparam int PRE_W = 7;            // prescaler counter width (div up to 128)
    localparam int DEV_W = 7;            // spread-spectrum deviation width
    localparam int PH_W  = 4;            // phase length field width
    localparam int AW    = 2;
    localparam int DW    = 32;
    localparam int DONE_LSB = 16;
    localparam int ST_W  = DONE_LSB + NGRP;

    localparam logic [AW-1:0] A_CTRL = 2'd0;
    localparam logic [AW-1:0] A_GRP  = 2'd1;
    localparam logic [AW-1:0] A_IEN  = 2'd2;
    localparam logic [AW-1:0] A_CLR  = 2'd3;

    typedef enum logic [2:0] {
        S_IDLE, S_WAIT, S_HIGH, S_HEXT, S_LOW
    } seq_state_t;

    typedef struct packed {
        logic [DEV_W-1:0] ss_dev;
        logic [PH_W-1:0]  lo_m1;
        logic [PH_W-1:0]  hi_m1;
        logic [2:0]       max_code;
        logic [2:0]       pg_code;
        logic             ss_div2;
        logic             ss_en;
        logic             idle_float;
        logic             sync_pol;
        logic             sync_mode;
    } acq_cfg_t;

    function automatic acq_cfg_t unpack_ctrl(input logic [DW-1:0] d);
        acq_cfg_t c;
        c.sync_mode  = d[1];
        c.sync_pol   = d[2];
        c.idle_float = d[3];
        c.ss_en      = d[4];
        c.ss_div2    = d[5];
        c.pg_code    = d[8:6];
        c.max_code   = d[11:9];
        c.hi_m1      = d[15:12];
        c.lo_m1      = d[19:16];
        c.ss_dev     = d[26:20];
        return c;
    endfunction

    // Short low phases are not allowed at the two fastest pulse clocks.
    function automatic logic timing_ok(input logic [2:0] pg, input logic [PH_W-1:0] lo);
        return !((pg == 3'd0 && lo == 4'd1) || (pg == 3'd1 && lo == 4'd0));
    endfunction

    // 2^(code+8)-1, code saturated at 6
    function automatic logic [CW-1:0] max_count(input logic [2:0] code);
        logic [CW-1:0] ones;
        logic [2:0]    c;
        ones = '1;
        c    = (code > 3'd6) ? 3'd6 : code;
        return ones >> (3'd6 - c);
    endfunction

endpackage

// File: rtl/ctouch_regs.sv
module ctouch_regs
    import ctouch_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            busy,
    output acq_cfg_t        cfg,
    output logic [NGRP-1:0] grp_en,
    output logic [1:0]      irq_en,
    output logic            start_req,
    output logic            start_wait,
    output logic [1:0]      flag_clr
);

    acq_cfg_t wr_cfg;
    logic     ctrl_wr;
    logic     unused_wr;

    assign wr_cfg     = unpack_ctrl(wr_data);
    assign unused_wr  = ^wr_data[DW-1:27];
    assign ctrl_wr    = wr_en && (wr_addr == A_CTRL) && !busy;
    assign start_req  = ctrl_wr && wr_data[0] && timing_ok(wr_cfg.pg_code, wr_cfg.lo_m1);
    assign start_wait = wr_cfg.sync_mode;
    assign flag_clr   = (wr_en && wr_addr == A_CLR) ? wr_data[1:0] : 2'b00;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            grp_en <= '0;
            irq_en <= '0;
        end else begin
            if (ctrl_wr)
                cfg <= wr_cfg;
            if (wr_en && wr_addr == A_GRP && !busy)
                grp_en <= wr_data[NGRP-1:0];
            if (wr_en && wr_addr == A_IEN)
                irq_en <= wr_data[1:0];
        end
    end

    // R12: configuration frozen across a running acquisition
    a_r12_cfg_locked: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(cfg) && $stable(grp_en));

endmodule

// File: rtl/ctouch_seq.sv
module ctouch_seq
    import ctouch_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  acq_cfg_t cfg,
    input  logic     start_req,
    input  logic     start_wait,
    input  logic     sync_in,
    input  logic     finish,
    output logic     busy,
    output logic     running,
    output logic     high_out,
    output logic     pair_end
);

    seq_state_t       st;
    logic [PRE_W-1:0] pre_cnt, pre_mask;
    logic [PRE_W:0]   mask_w;
    logic [PH_W-1:0]  ph_cnt;
    logic [DEV_W:0]   ext_cnt, ext_len;
    logic [DEV_W-1:0] lfsr, jitter;
    logic             ss_tog, sync_q, trig, tick;
    logic             unused_cfg;

    assign unused_cfg = ^{cfg.idle_float, cfg.max_code, cfg.sync_mode};

    assign mask_w   = (PRE_W+1)'(1) << cfg.pg_code;
    assign pre_mask = PRE_W'(mask_w - 1'b1);
    assign tick     = (pre_cnt & pre_mask) == pre_mask;
    assign trig     = cfg.sync_pol ? sync_in : (sync_q & ~sync_in);
    assign jitter   = (lfsr > cfg.ss_dev) ? cfg.ss_dev : lfsr;
    assign ext_len  = cfg.ss_div2 ? {jitter, 1'b0} : {1'b0, jitter};

    assign pair_end = (st == S_LOW) && tick && (ph_cnt == cfg.lo_m1);
    assign busy     = (st != S_IDLE);
    assign running  = (st == S_HIGH) || (st == S_HEXT) || (st == S_LOW);
    assign high_out = (st == S_HIGH) || (st == S_HEXT);

    // jitter source: 7-bit maximal LFSR, stepped at the spread-spectrum rate
    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr   <= 7'h5A;
            ss_tog <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            ss_tog <= ~ss_tog;
            sync_q <= sync_in;
            if (!cfg.ss_div2 || ss_tog)
                lfsr <= {lfsr[5:0], lfsr[6] ^ lfsr[5]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            pre_cnt <= '0;
            ph_cnt  <= '0;
            ext_cnt <= '0;
        end else begin
            case (st)
                S_IDLE: if (start_req) begin
                    st      <= start_wait ? S_WAIT : S_HIGH;
                    pre_cnt <= '0;
                    ph_cnt  <= '0;
                end
                S_WAIT: if (trig) begin
                    st      <= S_HIGH;
                    pre_cnt <= '0;
                    ph_cnt  <= '0;
                end
                S_HIGH: begin
                    pre_cnt <= pre_cnt + 1'b1;
                    if (tick) begin
                        if (ph_cnt == cfg.hi_m1) begin
                            ph_cnt <= '0;
                            if (cfg.ss_en && ext_len != '0) begin
                                st      <= S_HEXT;
                                ext_cnt <= ext_len - 1'b1;
                            end else begin
                                st <= S_LOW;
                            end
                        end else begin
                            ph_cnt <= ph_cnt + 1'b1;
                        end
                    end
                end
                S_HEXT: begin
                    // prescaler frozen so the low phase stays aligned
                    if (ext_cnt == '0) st <= S_LOW;
                    else               ext_cnt <= ext_cnt - 1'b1;
                end
                S_LOW: begin
                    pre_cnt <= pre_cnt + 1'b1;
                    if (tick) begin
                        if (ph_cnt == cfg.lo_m1) begin
                            ph_cnt <= '0;
                            st     <= finish ? S_IDLE : S_HIGH;
                        end else begin
                            ph_cnt <= ph_cnt + 1'b1;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    a_r3_high_phase_bound: assert property (@(posedge clk) disable iff (rst)
        st == S_HIGH |-> ph_cnt <= cfg.hi_m1);
    a_r3_low_phase_bound: assert property (@(posedge clk) disable iff (rst)
        st == S_LOW |-> ph_cnt <= cfg.lo_m1);
    a_r9_stretch_bound: assert property (@(posedge clk) disable iff (rst)
        st == S_HEXT |-> ext_cnt < {cfg.ss_dev, 1'b0});

endmodule

// File: rtl/ctouch_groups.sv
module ctouch_groups
    import ctouch_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             busy,
    input  logic             pair_end,
    input  logic [NGRP-1:0]  grp_en,
    input  logic [NGRP-1:0]  samp_in,
    input  logic [2:0]       max_code,
    output logic [NGRP*CW-1:0] cnt_flat,
    output logic [NGRP-1:0]  done_q,
    output logic             finish,
    output logic             err
);

    logic [CW-1:0]   max_val;
    logic [NGRP-1:0] trip, hit;

    assign max_val = max_count(max_code);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [CW-1:0] cnt, inc;
        logic          done, act;

        assign act  = grp_en[g] & ~done;
        assign inc  = cnt + 1'b1;
        assign trip[g] = pair_end & act & samp_in[g];
        assign hit[g]  = pair_end & act & ~samp_in[g] & (inc == max_val);
        assign cnt_flat[g*CW +: CW] = cnt;
        assign done_q[g] = done;

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                cnt  <= '0;
                done <= 1'b0;
            end else if (pair_end && act) begin
                cnt <= inc;
                if (samp_in[g]) done <= 1'b1;
            end
        end

        // R6: a running counter never passes the selected limit
        a_r6_cnt_cap: assert property (@(posedge clk) disable iff (rst)
            busy |-> cnt <= max_val);
    end

    assign err    = |hit;
    assign finish = pair_end & ((&(done_q | trip | ~grp_en)) | err);

    // R4: only enabled groups can complete during a run
    a_r4_done_needs_en: assert property (@(posedge clk) disable iff (rst)
        busy |-> (done_q & ~grp_en) == '0);

endmodule

// File: rtl/ctouch_acq.sv
module ctouch_acq
    import ctouch_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [31:0]        wr_data,
    input  logic               sync_in,
    input  logic [6:0]         samp_in,
    output logic [6:0]         pad_oe,
    output logic [6:0]         pad_out,
    output logic [97:0]        grp_cnt,
    output logic [22:0]        grp_stat,
    output logic               eoa_flag,
    output logic               mce_flag,
    output logic               irq,
    output logic               busy,
    output logic               acq_active
);

    acq_cfg_t        cfg;
    logic [NGRP-1:0] grp_en, done_q;
    logic [1:0]      irq_en, flag_clr;
    logic            start_req, start_wait, running, high_out, pair_end, finish, err;

    ctouch_regs u_regs (
        .clk, .rst, .wr_en, .wr_addr, .wr_data, .busy,
        .cfg, .grp_en, .irq_en, .start_req, .start_wait, .flag_clr
    );

    ctouch_seq u_seq (
        .clk, .rst, .cfg, .start_req, .start_wait, .sync_in, .finish,
        .busy, .running, .high_out, .pair_end
    );

    ctouch_groups u_grp (
        .clk, .rst, .clear(start_req), .busy, .pair_end, .grp_en, .samp_in,
        .max_code(cfg.max_code), .cnt_flat(grp_cnt), .done_q, .finish, .err
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            eoa_flag <= 1'b0;
            mce_flag <= 1'b0;
        end else begin
            eoa_flag <= finish | (eoa_flag & ~flag_clr[0]);
            mce_flag <= err    | (mce_flag & ~flag_clr[1]);
        end
    end

    assign irq        = (eoa_flag & irq_en[0]) | (mce_flag & irq_en[1]);
    assign acq_active = running;
    assign grp_stat   = {done_q, {(DONE_LSB-NGRP){1'b0}}, grp_en};

    for (genvar g = 0; g < NGRP; g++) begin : g_pad
        assign pad_oe[g]  = (running & grp_en[g]) | ~cfg.idle_float;
        assign pad_out[g] = running & grp_en[g] & ~done_q[g] & high_out;
    end

    a_r5_eoa_means_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(eoa_flag) |-> !busy);
    a_r6_error_ends_run: assert property (@(posedge clk) disable iff (rst)
        $rose(mce_flag) |-> eoa_flag);
    a_r2_quiet_pads: assert property (@(posedge clk) disable iff (rst)
        !acq_active |-> pad_out == '0);
    a_r10_clear_eoa: assert property (@(posedge clk) disable iff (rst)
        $past(flag_clr[0]) && !$past(finish) |-> !eoa_flag);

endmodule

// File: tb/sim_ctouch_acq.sv
module sim_ctouch_acq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        sync_in = 1'b0;
    logic [6:0]  samp_in = '0;
    logic [6:0]  pad_oe, pad_out;
    logic [97:0] grp_cnt;
    logic [22:0] grp_stat;
    logic        eoa_flag, mce_flag, irq, busy, acq_active;

    ctouch_acq u0 (
        .clk, .rst, .wr_en, .wr_addr, .wr_data, .sync_in, .samp_in,
        .pad_oe, .pad_out, .grp_cnt, .grp_stat, .eoa_flag, .mce_flag,
        .irq, .busy, .acq_active
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // sampling-input model: group g trips when its tgt-th pulse is seen
    int         tgt [7];
    int         seen [7];
    int         run_id = 0;
    int         last_id = 0;
    logic [6:0] pad_prev = '0;

    always @(negedge clk) begin
        if (run_id != last_id) begin
            last_id = run_id;
            for (int g = 0; g < 7; g++) seen[g] = 0;
            samp_in  = '0;
            pad_prev = pad_out;
        end else begin
            for (int g = 0; g < 7; g++) begin
                if (pad_out[g] && !pad_prev[g]) begin
                    seen[g]++;
                    if (tgt[g] != 0 && seen[g] >= tgt[g]) samp_in[g] = 1'b1;
                end
            end
            pad_prev = pad_out;
        end
    end

    task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_in(input string req, input string what, input longint act, input longint lo, input longint hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input bit st, input bit smode, input bit spol,
            input bit flt, input bit ssen, input bit ssd2, input int pg, input int mx,
            input int hi, input int lo, input int dev);
        logic [31:0] d;
        d = '0;
        d[0] = st; d[1] = smode; d[2] = spol; d[3] = flt; d[4] = ssen; d[5] = ssd2;
        d[8:6] = pg[2:0]; d[11:9] = mx[2:0]; d[15:12] = hi[3:0]; d[19:16] = lo[3:0];
        d[26:20] = dev[6:0];
        return d;
    endfunction

    function automatic int cnt_of(input int g);
        return int'(grp_cnt[g*14 +: 14]);
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic arm(input int t0, input int t1, input int t2, input int t3,
                       input int t4, input int t5, input int t6);
        tgt[0] = t0; tgt[1] = t1; tgt[2] = t2; tgt[3] = t3;
        tgt[4] = t4; tgt[5] = t5; tgt[6] = t6;
        run_id++;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_idle;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic meas(output int hw, output int lw);
        while (pad_out[0]) @(negedge clk);
        while (!pad_out[0]) @(negedge clk);
        hw = 0;
        while (pad_out[0]) begin hw++; @(negedge clk); end
        lw = 0;
        while (!pad_out[0]) begin lw++; @(negedge clk); end
    endtask

    task automatic t_reset;
        chk_eq("R1", "busy", busy, 0);
        chk_eq("R1", "acq_active", acq_active, 0);
        chk_eq("R1", "flags+irq", {eoa_flag, mce_flag, irq}, 0);
        chk_eq("R1", "grp_stat", grp_stat, 0);
        chk_eq("R1", "counters zero", (grp_cnt == '0), 1);
        chk_eq("R1", "pad_out", pad_out, 0);
        chk_eq("R1", "pad_oe", pad_oe, 7'h7F);
    endtask

    task automatic t_idle_pads;
        wr(2'd0, mk_ctrl(0,0,0,1,0,0,0,0,0,0,0));
        chk_eq("R2", "pad_oe released", pad_oe, 0);
        chk_eq("R2", "pad_out released", pad_out, 0);
        wr(2'd0, mk_ctrl(0,0,0,0,0,0,0,0,0,0,0));
        chk_eq("R2", "pad_oe driven low", pad_oe, 7'h7F);
    endtask

    task automatic width_case(input int pg, input int hi, input int lo);
        int hw, lw;
        arm(4,0,0,0,0,0,0);
        wr(2'd0, mk_ctrl(1,0,0,0,0,0,pg,0,hi,lo,0));
        chk_eq("R2", "enabled pad driven while pulsing", pad_oe[0], 1);
        meas(hw, lw);
        chk_eq("R3", $sformatf("high width pg%0d hi%0d", pg, hi), hw, (hi+1) << pg);
        chk_eq("R3", $sformatf("low width pg%0d lo%0d", pg, lo), lw, (lo+1) << pg);
        wait_idle();
        chk_eq("R4", "single group count", cnt_of(0), 4);
    endtask

    task automatic t_widths;
        wr(2'd1, 32'h1);
        width_case(0, 2, 0);
        width_case(2, 1, 3);
        width_case(3, 0, 0);
        width_case(1, 3, 1);
    endtask

    task automatic t_multi;
        wr(2'd1, 32'h57);
        arm(3,7,1,0,5,0,2);
        wr(2'd0, mk_ctrl(1,0,0,0,0,0,0,6,0,0,0));
        chk_eq("R7", "normal mode starts at once", acq_active, 1);
        wait_idle();
        chk_eq("R4", "g0 count", cnt_of(0), 3);
        chk_eq("R4", "g1 count", cnt_of(1), 7);
        chk_eq("R4", "g2 count", cnt_of(2), 1);
        chk_eq("R4", "g3 disabled count", cnt_of(3), 0);
        chk_eq("R4", "g4 count", cnt_of(4), 5);
        chk_eq("R4", "g5 disabled count", cnt_of(5), 0);
        chk_eq("R4", "g6 count", cnt_of(6), 2);
        chk_eq("R4", "completion bits", grp_stat[22:16], 7'h57);
        chk_eq("R4", "enable bits", grp_stat[6:0], 7'h57);
        chk_eq("R5", "end flag", eoa_flag, 1);
        chk_eq("R5", "no error", mce_flag, 0);
        chk_eq("R5", "start self-cleared", busy, 0);
        repeat (10) @(negedge clk);
        chk_eq("R5", "counter holds", cnt_of(1), 7);
        arm(1,1,1,1,1,1,1);
        wr(2'd0, mk_ctrl(1,0,0,0,0,0,2,6,15,15,0));
        chk_eq("R5", "counter cleared at start", cnt_of(1), 0);
        chk_eq("R5", "completion cleared at start", grp_stat[22:16], 0);
        wait_idle();
        chk_eq("R5", "short run count", cnt_of(4), 1);
        wr(2'd3, 32'h3);
    endtask

    task automatic t_max_flags;
        wr(2'd1, 32'h1);
        wr(2'd2, 32'h3);
        arm(0,0,0,0,0,0,0);
        wr(2'd0, mk_ctrl(1,0,0,0,0,0,0,0,0,0,0));
        wait_idle();
        chk_eq("R6", "limit 255", cnt_of(0), 255);
        chk_eq("R6", "error flag", mce_flag, 1);
        chk_eq("R6", "end flag with error", eoa_flag, 1);
        chk_eq("R6", "no completion on error", grp_stat[16], 0);
        chk_eq("R10", "irq enabled", irq, 1);
        wr(2'd3, 32'h1);
        chk_eq("R10", "end flag cleared", eoa_flag, 0);
        chk_eq("R10", "error flag kept", mce_flag, 1);
        wr(2'd2, 32'h1);
        chk_eq("R10", "error masked", irq, 0);
        wr(2'd3, 32'h2);
        chk_eq("R10", "error flag cleared", mce_flag, 0);
        wr(2'd2, 32'h0);
        arm(0,0,0,0,0,0,0);
        wr(2'd0, mk_ctrl(1,0,0,0,0,0,0,1,0,0,0));
        wait_idle();
        chk_eq("R6", "limit 511", cnt_of(0), 511);
        chk_eq("R10", "irq all masked", irq, 0);
        wr(2'd2, 32'h2);
        chk_eq("R10", "irq on error enable", irq, 1);
        wr(2'd3, 32'h3);
        chk_eq("R10", "irq after clear", irq, 0);
        wr(2'd2, 32'h0);
    endtask

    task automatic t_illegal;
        arm(1,0,0,0,0,0,0);
        wr(2'd0, mk_ctrl(1,0,0,0,0,0,0,0,0,1,0));
        repeat (4) @(negedge clk);
        chk_eq("R11", "div1 low2 refused", {busy, acq_active, pad_out[0]}, 0);
        wr(2'd0, mk_ctrl(1,0,0,0,0,0,1,0,0,0,0));
        repeat (4) @(negedge clk);
        chk_eq("R11", "div2 low1 refused", {busy, acq_active, pad_out[0]}, 0);
        wr(2'd0, mk_ctrl(1,0,0,0,0,0,1,0,0,1,0));
        chk_eq("R11", "div2 low2 accepted", busy, 1);
        wait_idle();
    endtask

    task automatic t_sync;
        sync_in = 1'b1;
        arm(1,0,0,0,0,0,0);
        wr(2'd0, mk_ctrl(1,1,0,0,0,0,0,0,0,0,0));
        repeat (10) @(negedge clk);
        chk_eq("R7", "waiting on high level", {busy, acq_active}, 2'b10);
        chk_eq("R7", "no pulses while waiting", pad_out, 0);
        sync_in = 1'b0;
        @(negedge clk);
        chk_eq("R7", "falling edge starts", acq_active, 1);
        wait_idle();
        arm(1,0,0,0,0,0,0);
        wr(2'd0, mk_ctrl(1,1,1,0,0,0,0,0,0,0,0));
        repeat (10) @(negedge clk);
        chk_eq("R8", "waiting while low", {busy, acq_active}, 2'b10);
        sync_in = 1'b1;
        @(negedge clk);
        chk_eq("R8", "high level starts", acq_active, 1);
        wait_idle();
        sync_in = 1'b0;
    endtask

    task automatic ss_case(input bit d2, input int dev, input bit want_exact);
        int hw, lw, over, mul;
        mul = d2 ? 2 : 1;
        over = 0;
        arm(40,0,0,0,0,0,0);
        wr(2'd0, mk_ctrl(1,0,0,0,1,d2,0,6,3,0,dev));
        for (int i = 0; i < 8; i++) begin
            meas(hw, lw);
            if (want_exact) chk_eq("R9", "zero deviation exact", hw, 4);
            else begin
                chk_in("R9", "stretched width", hw, 4, 4 + dev*mul);
                chk_eq("R9", "stretch in whole steps", (hw - 4) % mul, 0);
            end
            if (hw > 4) over = 1;
        end
        if (!want_exact) chk_eq("R9", "some stretch seen", over, 1);
        wait_idle();
    endtask

    task automatic t_spread;
        wr(2'd1, 32'h1);
        ss_case(0, 0, 1);
        ss_case(0, 5, 0);
        ss_case(1, 3, 0);
        wr(2'd3, 32'h3);
    endtask

    task automatic t_lock;
        int hw, lw;
        wr(2'd1, 32'h1);
        arm(30,0,0,0,0,0,0);
        wr(2'd0, mk_ctrl(1,0,0,0,0,0,0,6,5,2,0));
        meas(hw, lw);
        chk_eq("R3", "width before write", hw, 6);
        wr(2'd0, mk_ctrl(1,0,0,0,0,0,0,6,1,2,0));
        wr(2'd1, 32'h7F);
        chk_eq("R12", "group enables unchanged", grp_stat[6:0], 7'h01);
        meas(hw, lw);
        chk_eq("R12", "width unchanged while busy", hw, 6);
        wait_idle();
        chk_eq("R12", "run completes as set", cnt_of(0), 30);
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        for (int g = 0; g < 7; g++) tgt[g] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle_pads();
        t_widths();
        t_multi();
        t_max_flags();
        t_illegal();
        t_sync();
        t_spread();
        t_lock();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        finish_run();
    end

endmodule